// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block lives in the decode stage of an in-order five-stage pipeline. Consider the instruction that has just left decode and sits in execute. If it reads data memory, and the instruction now in decode names that loaded register as either of its two source fields, forwarding cannot supply the value in time. The interlock then holds fetch and decode for one cycle and sends an all-zero control word into execute in place of the decoded one.

The block also carries a small registered model of the program counter and three pipeline registers:
- fetch/decode, which holds the instruction;
- decode/execute, which holds the control word and the target-register field;
- execute/memory, which holds the control word only.

With this model the hold, the bubble and the continued progress of older instructions can be observed cycle by cycle. The main decoder sits outside the block and supplies the control word for the instruction held in fetch/decode. The instruction memory also sits outside and supplies the word addressed by the program counter. The datapath and the forwarding network are not part of this block.

Top module: `load_use_interlock`

## Requirements
- R1: `stall` is high exactly when the decode/execute control word has its memory-read bit (bit 3) set and the decode/execute target field equals either source field of the fetch/decode instruction. The first source field is bits 25:21 and the second is bits 20:16.
- R2: While `stall` is high, `pc_wr_en` and `ifid_wr_en` are low, and the program counter and fetch/decode instruction keep their values at the next edge. While `stall` is low, both enables are high, the program counter advances by 4 and fetch/decode loads `fetch_insn`.
- R3: While `stall` is high, `idex_ctrl_next` is all zero and decode/execute loads a zero control word. Otherwise decode/execute loads `dec_ctrl` unchanged.
- R4: Execute/memory loads the decode/execute control word at every edge, stall or not, so the load and older instructions keep moving.
- R5: A stall never lasts more than one cycle: the cycle after a stall always has `stall` low.
- R6: The control word is 9 bits. From bit 8 down to bit 0 they are: destination-select, ALU op high, ALU op low, ALU source, branch, memory read, memory write, register write, memory-to-register. The word values are: register-register 9'h182, load 9'h02B, store 9'h024, branch-if-equal 9'h050.
- R7: A synchronous active-low reset clears the program counter, fetch/decode, decode/execute and execute/memory registers to zero, and `stall` is low afterwards.
- R8: When the decode/execute memory-read bit is clear, `stall` stays low even if the register fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_insn | input | INSN_W | Instruction word at the current program counter |
| dec_ctrl | input | 9 | Decoded control word for the fetch/decode instruction |
| pc_q | output | PC_W | Program counter |
| ifid_insn_q | output | INSN_W | Fetch/decode instruction register |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode write enable |
| stall | output | 1 | Load-use stall request |
| idex_ctrl_next | output | 9 | Control word offered to decode/execute |
| idex_ctrl_q | output | 9 | Decode/execute control word |
| idex_rt_q | output | REG_AW | Decode/execute target-register field |
| exmem_ctrl_q | output | 9 | Execute/memory control word |

## Verification
The assertions take two things for granted:
- `dec_ctrl` is a legal word from the R6 table for whatever instruction sits in fetch/decode;
- `fetch_insn` follows `pc_q` the way an instruction memory would.

This matters because a decoded word with the memory-read bit set can only enter execute through an actual load. The bench keeps to both assumptions by modelling the instruction memory and the decoder itself: it looks up its own program by `pc_q` and decodes the opcode of `ifid_insn_q`. The program mixes the following cases:
- loads followed by users through the first source field and through the second source field;
- a load followed by an unrelated instruction;
- a register match behind a non-load.

// File: rtl/lui_pkg.sv
// Package: shared constants for the load-use interlock.
// Holds the control-word layout (bit 8 = destination-select down to
// bit 0 = memory-to-register), the instruction field positions that the
// hazard compare decodes, and the per-class control words.
package lui_pkg;

    localparam int CTRL_W = 9;

    // Control-word bit indices.
    localparam int CB_DST_SEL  = 8;
    localparam int CB_ALU_HI   = 7;
    localparam int CB_ALU_LO   = 6;
    localparam int CB_ALU_SRC  = 5;
    localparam int CB_BRANCH   = 4;
    localparam int CB_MEM_RD   = 3;
    localparam int CB_MEM_WR   = 2;
    localparam int CB_REG_WR   = 1;
    localparam int CB_MEM2REG  = 0;

    // Source field positions inside an instruction word.
    localparam int SRC_A_LSB = 21;
    localparam int SRC_B_LSB = 16;

    typedef logic [CTRL_W-1:0] ctrl_word_t;

    // Decoded words per instruction class; don't-care bits are zero.
    localparam ctrl_word_t CW_REGREG = 9'h182;
    localparam ctrl_word_t CW_LOAD   = 9'h02B;
    localparam ctrl_word_t CW_STORE  = 9'h024;
    localparam ctrl_word_t CW_BEQ    = 9'h050;
    localparam ctrl_word_t CW_BUBBLE = '0;

endpackage

// File: rtl/lui_hazard_detect.sv
// Module: load-use hazard compare.
// Raises stall when the execute-stage instruction reads memory and its
// target field matches either source field of the decode instruction.
// Both write enables are the inverse of stall. Purely combinational.
// Assumes the field inputs are already sliced by the caller.
module lui_hazard_detect #(
    parameter int REG_AW = 5
) (
    input  logic              ex_mem_read,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    output logic              stall,
    output logic              pc_we,
    output logic              ifid_we
);

    logic hit_a;
    logic hit_b;

    // Compare the pending load target against each decode source.
    always_comb begin
        hit_a = (ex_dst == dec_src_a);
        hit_b = (ex_dst == dec_src_b);
    end

    // A match only matters when execute holds a memory read.
    always_comb begin
        stall   = ex_mem_read && (hit_a || hit_b);
        pc_we   = !stall;
        ifid_we = !stall;
    end

endmodule

// File: rtl/lui_bubble_mux.sv
// Module: control-word bubble selector.
// Passes the decoded control word through, or forces every bit to zero
// when kill is high, so execute receives a no-op. One gate per bit.
module lui_bubble_mux #(
    parameter int W = 9
) (
    input  logic         kill,
    input  logic [W-1:0] ctrl_in,
    output logic [W-1:0] ctrl_out
);

    // Gate each control bit with the kill request.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign ctrl_out[i] = ctrl_in[i] & ~kill;
    end

endmodule

// File: rtl/lui_stage_regs.sv
// Module: registered model of the front of the pipeline.
// Holds the program counter, the fetch/decode instruction, the
// decode/execute control word and target field, and the execute/memory
// control word. The program counter and fetch/decode load only when
// their enables are high; the later registers load at every edge.
// Synchronous active-low reset clears every register.
module lui_stage_regs #(
    parameter int PC_W   = 32,
    parameter int INSN_W = 32,
    parameter int REG_AW = 5,
    parameter int CW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_we,
    input  logic              ifid_we,
    input  logic [INSN_W-1:0] fetch_insn,
    input  logic [CW-1:0]     idex_ctrl_d,
    input  logic [REG_AW-1:0] idex_rt_d,
    output logic [PC_W-1:0]   pc_q,
    output logic [INSN_W-1:0] ifid_q,
    output logic [CW-1:0]     idex_ctrl_q,
    output logic [REG_AW-1:0] idex_rt_q,
    output logic [CW-1:0]     exmem_ctrl_q
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    // Program counter: step by one word unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_q + PC_STEP;
    end

    // Fetch/decode register: capture the fetched word unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)       ifid_q <= '0;
        else if (ifid_we) ifid_q <= fetch_insn;
    end

    // Decode/execute register: always advances, bubble or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_ctrl_q <= '0;
            idex_rt_q   <= '0;
        end else begin
            idex_ctrl_q <= idex_ctrl_d;
            idex_rt_q   <= idex_rt_d;
        end
    end

    // Execute/memory register: older instructions never wait.
    always_ff @(posedge clk) begin
        if (!rst_n) exmem_ctrl_q <= '0;
        else        exmem_ctrl_q <= idex_ctrl_q;
    end

endmodule

// File: rtl/load_use_interlock.sv
// Module: load-use interlock, top level.
// Slices the source fields of the fetch/decode instruction, compares
// them with the execute-stage load target, and on a hit holds the
// program counter and fetch/decode while zeroing the control word that
// enters execute. Assumes dec_ctrl is the decoder output for the word
// in fetch/decode, and fetch_insn is the word addressed by pc_q.
module load_use_interlock #(
    parameter int PC_W   = 32,
    parameter int INSN_W = 32,
    parameter int REG_AW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [INSN_W-1:0]         fetch_insn,
    input  logic [lui_pkg::CTRL_W-1:0] dec_ctrl,
    output logic [PC_W-1:0]           pc_q,
    output logic [INSN_W-1:0]         ifid_insn_q,
    output logic                      pc_wr_en,
    output logic                      ifid_wr_en,
    output logic                      stall,
    output logic [lui_pkg::CTRL_W-1:0] idex_ctrl_next,
    output logic [lui_pkg::CTRL_W-1:0] idex_ctrl_q,
    output logic [REG_AW-1:0]         idex_rt_q,
    output logic [lui_pkg::CTRL_W-1:0] exmem_ctrl_q
);

    import lui_pkg::*;

    logic [REG_AW-1:0] dec_src_a;
    logic [REG_AW-1:0] dec_src_b;

    // Slice both source fields out of the decode instruction.
    always_comb begin
        dec_src_a = ifid_insn_q[SRC_A_LSB +: REG_AW];
        dec_src_b = ifid_insn_q[SRC_B_LSB +: REG_AW];
    end

    lui_hazard_detect #(
        .REG_AW (REG_AW)
    ) u_detect (
        .ex_mem_read (idex_ctrl_q[CB_MEM_RD]),
        .ex_dst      (idex_rt_q),
        .dec_src_a   (dec_src_a),
        .dec_src_b   (dec_src_b),
        .stall       (stall),
        .pc_we       (pc_wr_en),
        .ifid_we     (ifid_wr_en)
    );

    lui_bubble_mux #(
        .W (CTRL_W)
    ) u_bubble (
        .kill     (stall),
        .ctrl_in  (dec_ctrl),
        .ctrl_out (idex_ctrl_next)
    );

    lui_stage_regs #(
        .PC_W   (PC_W),
        .INSN_W (INSN_W),
        .REG_AW (REG_AW),
        .CW     (CTRL_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_we        (pc_wr_en),
        .ifid_we      (ifid_wr_en),
        .fetch_insn   (fetch_insn),
        .idex_ctrl_d  (idex_ctrl_next),
        .idex_rt_d    (dec_src_b),
        .pc_q         (pc_q),
        .ifid_q       (ifid_insn_q),
        .idex_ctrl_q  (idex_ctrl_q),
        .idex_rt_q    (idex_rt_q),
        .exmem_ctrl_q (exmem_ctrl_q)
    );

endmodule

// File: rtl/lui_checker.sv
// Module: temporal checks for the load-use interlock, bound to the top.
// Assumes dec_ctrl only carries words from the class table.
module lui_checker #(
    parameter int PC_W   = 32,
    parameter int INSN_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic [PC_W-1:0]   pc_q,
    input logic [INSN_W-1:0] ifid_insn_q,
    input logic [8:0]        idex_ctrl_q,
    input logic [8:0]        exmem_ctrl_q
);

    // R2: a stall freezes the program counter and the decode instruction.
    p_hold_front_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(pc_q) && $stable(ifid_insn_q)));

    // R2: without a stall the program counter steps by one word.
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall) |=> (pc_q == $past(pc_q) + PC_W'(4)));

    // R3: the cycle after a stall, execute holds an all-zero word.
    p_bubble_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (idex_ctrl_q == 9'h000));

    // R4: execute/memory always takes what execute held.
    p_older_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (exmem_ctrl_q == $past(idex_ctrl_q)));

    // R5: no two stall cycles in a row.
    p_single_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R8: no memory read in execute, no stall.
    p_no_read_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idex_ctrl_q[3]) |-> !stall);

    // R7: reset clears the model and drops the stall.
    p_reset_clear_r7: assert property (@(posedge clk)
        (!rst_n) |=> (pc_q == '0 && idex_ctrl_q == 9'h000 && !stall));

endmodule

bind load_use_interlock lui_checker #(
    .PC_W   (PC_W),
    .INSN_W (INSN_W)
) u_lui_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .pc_q         (pc_q),
    .ifid_insn_q  (ifid_insn_q),
    .idex_ctrl_q  (idex_ctrl_q),
    .exmem_ctrl_q (exmem_ctrl_q)
);

// File: tb/test_load_use_interlock.sv
`timescale 1ns/1ps
module test_load_use_interlock;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_insn;
    logic [8:0]  dec_ctrl;
    logic [31:0] pc_q;
    logic [31:0] ifid_insn_q;
    logic        pc_wr_en, ifid_wr_en, stall;
    logic [8:0]  idex_ctrl_next, idex_ctrl_q, exmem_ctrl_q;
    logic [4:0]  idex_rt_q;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    load_use_interlock i_load_use_interlock (
        .clk(clk), .rst_n(rst_n), .fetch_insn(fetch_insn), .dec_ctrl(dec_ctrl),
        .pc_q(pc_q), .ifid_insn_q(ifid_insn_q), .pc_wr_en(pc_wr_en),
        .ifid_wr_en(ifid_wr_en), .stall(stall), .idex_ctrl_next(idex_ctrl_next),
        .idex_ctrl_q(idex_ctrl_q), .idex_rt_q(idex_rt_q), .exmem_ctrl_q(exmem_ctrl_q)
    );

    // Program: load, dependent user, load, independent, load behind a
    // non-load match, store using it, load, branch using it via 2nd field.
    localparam logic [31:0] PROG [8] = '{
        {6'd35, 5'd2,  5'd1,  16'd4},              // lw  $1,4($2)
        {6'd0,  5'd1,  5'd5,  5'd4, 5'd0, 6'd34},  // sub $4,$1,$5
        {6'd35, 5'd2,  5'd3,  16'd0},              // lw  $3,0($2)
        {6'd0,  5'd7,  5'd8,  5'd6, 5'd0, 6'd32},  // add $6,$7,$8
        {6'd35, 5'd8,  5'd9,  16'd0},              // lw  $9,0($8)
        {6'd43, 5'd9,  5'd10, 16'd0},              // sw  $10,0($9)
        {6'd35, 5'd2,  5'd11, 16'd0},              // lw  $11,0($2)
        {6'd4,  5'd12, 5'd11, 16'd0}               // beq $12,$11
    };

    // Instruction memory model; beyond the program, all-zero words.
    assign fetch_insn = (pc_q[31:2] < 30'd8) ? PROG[pc_q[4:2]] : 32'h0;

    // Decoder model from the R6 class table.
    function automatic logic [8:0] decode(input logic [31:0] w);
        case (w[31:26])
            6'd0:    return 9'h182;
            6'd35:   return 9'h02B;
            6'd43:   return 9'h024;
            6'd4:    return 9'h050;
            default: return 9'h000;
        endcase
    endfunction
    assign dec_ctrl = decode(ifid_insn_q);

    // Expected state after each edge: {pc[7:0], stall, idex ctrl, exmem ctrl}.
    localparam logic [26:0] EXP [14] = '{
        {8'd0,  1'b0, 9'h000, 9'h000},
        {8'd4,  1'b0, 9'h182, 9'h000},
        {8'd8,  1'b1, 9'h02B, 9'h182},  // lw $1 vs sub rs=$1
        {8'd8,  1'b0, 9'h000, 9'h02B},  // bubble, load moved on
        {8'd12, 1'b0, 9'h182, 9'h000},
        {8'd16, 1'b0, 9'h02B, 9'h182},  // independent add: no stall
        {8'd20, 1'b0, 9'h182, 9'h02B},  // add rt=$8 matches, no read
        {8'd24, 1'b1, 9'h02B, 9'h182},  // lw $9 vs sw rs=$9
        {8'd24, 1'b0, 9'h000, 9'h02B},
        {8'd28, 1'b0, 9'h024, 9'h000},
        {8'd32, 1'b1, 9'h02B, 9'h024},  // lw $11 vs beq rt=$11
        {8'd32, 1'b0, 9'h000, 9'h02B},
        {8'd36, 1'b0, 9'h050, 9'h000},
        {8'd40, 1'b0, 9'h182, 9'h050}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: state held under reset.
        check("R7 pc", pc_q, 32'h0);
        check("R7 ifid", ifid_insn_q, 32'h0);
        check("R7 stall", {31'h0, stall}, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 14; k++) begin
            check("R2 pc", pc_q, {24'h0, EXP[k][26:19]});
            check("R1 stall", {31'h0, stall}, {31'h0, EXP[k][18]});
            check("R2 pc_wr_en", {31'h0, pc_wr_en}, {31'h0, ~EXP[k][18]});
            check("R2 ifid_wr_en", {31'h0, ifid_wr_en}, {31'h0, ~EXP[k][18]});
            check("R3 idex ctrl", {23'h0, idex_ctrl_q}, {23'h0, EXP[k][17:9]});
            check("R4 exmem ctrl", {23'h0, exmem_ctrl_q}, {23'h0, EXP[k][8:0]});
            if (EXP[k][18])
                check("R3 ctrl next zero", {23'h0, idex_ctrl_next}, 32'h0);
            else if (k > 0)
                check("R6 ctrl next", {23'h0, idex_ctrl_next}, {23'h0, decode(ifid_insn_q)});
            if (k > 0 && EXP[k-1][18])
                check("R5 one cycle", {31'h0, stall}, 32'h0);
            @(posedge clk);
            @(negedge clk);
        end

        // R2: decode instruction held across a stall, then replaced.
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        // R7: mid-run reset clears everything.
        check("R7 pc", pc_q, 32'h0);
        check("R7 idex", {23'h0, idex_ctrl_q}, 32'h0);
        check("R7 exmem", {23'h0, exmem_ctrl_q}, 32'h0);
        check("R7 stall", {31'h0, stall}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R1 stall rs match", {31'h0, stall}, 32'h1);
        check("R6 load word", {23'h0, idex_ctrl_q}, 32'h02B);
        check("R2 ifid before", ifid_insn_q, PROG[1]);
        @(posedge clk); @(negedge clk);
        check("R2 ifid held", ifid_insn_q, PROG[1]);
        check("R2 pc held", pc_q, 32'd8);
        check("R5 stall cleared", {31'h0, stall}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R2 ifid advanced", ifid_insn_q, PROG[2]);
        check("R6 reg-reg word", {23'h0, idex_ctrl_q}, 32'h182);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule